// File: doc/BRIEF.md
# Address Translation Table

The block rewrites the top 12 bits of a 32-bit transaction address through a programmable lookup table. The upper address field, bits 31 to 20, names the target and serves as the table index. The looked-up value replaces that field. Bits 19 to 0 pass through untouched. Addresses arrive as a stream with a valid strobe, and each translated address leaves one cycle later with its own valid strobe.

A host programs and inspects the table over a simple 32-bit configuration bus. Each entry sits in its own 8-byte slot, so config address bits 14 to 3 pick the entry. After reset every entry holds its own index. The table therefore maps every address to itself until software changes it. An enable input turns translation off and passes every address through unchanged. The table holds `ENTRIES` entries. A key at or above `ENTRIES` has no entry and passes through untranslated.

Top module: `addr_xlat`

## Requirements
- R1: While reset is asserted and right after it, `out_valid` is 0, `out_addr` is 0 and `cfg_rdata` is 0.
- R2: `out_valid` equals `in_valid` from one cycle earlier. `out_addr` is loaded only in cycles where `in_valid` is 1, and it holds its value otherwise.
- R3: When `xl_en` is 1 and the key `in_addr[31:20]` is below `ENTRIES`, `out_addr` becomes `{entry[key], in_addr[19:0]}`.
- R4: A key of `ENTRIES` or above leaves the address unchanged, even when `xl_en` is 1.
- R5: When `xl_en` is 0, `out_addr` equals `in_addr` from the cycle before.
- R6: After reset, entry k holds the value k, so every translation is an identity until the table is written.
- R7: A cycle with `cfg_en`=1 and `cfg_we`=1 stores `cfg_wdata[11:0]` into the entry selected by `cfg_addr[14:3]`. `cfg_addr[2:0]` and `cfg_wdata[31:12]` are ignored.
- R8: A cycle with `cfg_en`=1 and `cfg_we`=0 loads `cfg_rdata` with `{20'b0, entry}` on the next cycle. In any other cycle `cfg_rdata` holds its value.
- R9: A config index of `ENTRIES` or above selects no entry. A write there changes no entry, and a read there returns 0.
- R10: When a config write and a translation fall in the same cycle, the translation uses the entry value from before that write. The next translation uses the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| xl_en | input | 1 | 1: translate, 0: pass addresses through unchanged |
| in_valid | input | 1 | Incoming address is valid |
| in_addr | input | 32 | Incoming address |
| out_valid | output | 1 | Translated address is valid |
| out_addr | output | 32 | Translated address |
| cfg_en | input | 1 | Config access strobe |
| cfg_we | input | 1 | Config access is a write when 1 |
| cfg_addr | input | 15 | Config byte address; bits 14:3 select the entry |
| cfg_wdata | input | 32 | Config write data |
| cfg_rdata | output | 32 | Config read data, valid one cycle after a read |

## Verification
The config write port and the translation lookup can touch the same entry in the same cycle. The bench first writes a known value into an entry. It then writes a second value to that entry in the same cycle as a translation whose key selects it. The translated address must carry the first value. The next translation of the same key must carry the second value, which shows that the write took effect one cycle after the lookup read the entry.

// File: rtl/addr_xlat_pkg.sv
package addr_xlat_pkg;
  localparam int ADDR_W   = 32;
  localparam int KEY_W    = 12;
  localparam int KEY_LSB  = ADDR_W - KEY_W;
  localparam int CFG_AW   = 15;
  localparam int SLOT_LSB = 3;
  localparam int DATA_W   = 32;

  typedef logic [KEY_W-1:0]  key_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;
endpackage

// File: rtl/xlat_rst_sync.sv
module xlat_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/xlat_entry.sv
module xlat_entry
  import addr_xlat_pkg::*;
#(
  parameter key_t RESET_VAL = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  key_t wr_data,
  output key_t value
);
  key_t value_q;
  key_t value_d;

  always_comb begin
    value_d = value_q;
    if (wr_en) value_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value_q <= RESET_VAL;
    else        value_q <= value_d;
  end

  assign value = value_q;
endmodule

// File: rtl/xlat_table.sv
module xlat_table
  import addr_xlat_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  key_t             wr_data,
  input  logic [IDX_W-1:0] lk_idx,
  output key_t             lk_val,
  input  logic [IDX_W-1:0] cfg_idx,
  output key_t             cfg_val
);
  key_t entry_val [ENTRIES];

  for (genvar k = 0; k < ENTRIES; k++) begin : g_entry
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(k));
    xlat_entry #(.RESET_VAL(key_t'(k))) u_entry (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (sel),
      .wr_data (wr_data),
      .value   (entry_val[k])
    );
  end

  always_comb begin
    lk_val  = '0;
    cfg_val = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      if (lk_idx  == IDX_W'(k)) lk_val  = entry_val[k];
      if (cfg_idx == IDX_W'(k)) cfg_val = entry_val[k];
    end
  end
endmodule

// File: rtl/xlat_cfg_port.sv
module xlat_cfg_port
  import addr_xlat_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  data_t             cfg_wdata,
  input  key_t              cfg_val,
  output logic              wr_en,
  output logic [IDX_W-1:0]  idx,
  output key_t              wr_data,
  output data_t             cfg_rdata
);
  logic  in_range;
  logic  rd_en;
  data_t rdata_q;
  data_t rdata_d;

  always_comb begin
    in_range = 32'(cfg_addr[SLOT_LSB +: KEY_W]) < 32'(ENTRIES);
    idx      = cfg_addr[SLOT_LSB +: IDX_W];
    wr_en    = cfg_en && cfg_we && in_range;
    rd_en    = cfg_en && !cfg_we;
    wr_data  = cfg_wdata[KEY_W-1:0];
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) rdata_d = in_range ? DATA_W'(cfg_val) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign cfg_rdata = rdata_q;
endmodule

// File: rtl/xlat_stage.sv
module xlat_stage
  import addr_xlat_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xl_en,
  input  logic             in_valid,
  input  addr_t            in_addr,
  output logic [IDX_W-1:0] lk_idx,
  input  key_t             lk_val,
  output logic             out_valid,
  output addr_t            out_addr
);
  key_t  key;
  logic  hit;
  addr_t addr_d;
  addr_t addr_q;
  logic  valid_q;

  always_comb begin
    key    = in_addr[ADDR_W-1:KEY_LSB];
    hit    = 32'(key) < 32'(ENTRIES);
    lk_idx = key[IDX_W-1:0];
    addr_d = addr_q;
    if (in_valid) begin
      if (xl_en && hit) addr_d = {lk_val, in_addr[KEY_LSB-1:0]};
      else              addr_d = in_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      valid_q <= in_valid;
      addr_q  <= addr_d;
    end
  end

  assign out_valid = valid_q;
  assign out_addr  = addr_q;
endmodule

// File: rtl/addr_xlat.sv
module addr_xlat
  import addr_xlat_pkg::*;
#(
  parameter int ENTRIES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xl_en,
  input  logic              in_valid,
  input  logic [31:0]       in_addr,
  output logic              out_valid,
  output logic [31:0]       out_addr,
  input  logic              cfg_en,
  input  logic              cfg_we,
  input  logic [14:0]       cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic             rst_sync_n;
  logic             wr_en;
  logic [IDX_W-1:0] cfg_idx;
  logic [IDX_W-1:0] lk_idx;
  key_t             wr_data;
  key_t             lk_val;
  key_t             cfg_val;

  xlat_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  xlat_table #(.ENTRIES(ENTRIES)) u_table (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_idx  (cfg_idx),
    .wr_data (wr_data),
    .lk_idx  (lk_idx),
    .lk_val  (lk_val),
    .cfg_idx (cfg_idx),
    .cfg_val (cfg_val)
  );

  xlat_cfg_port #(.ENTRIES(ENTRIES)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_en    (cfg_en),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_val   (cfg_val),
    .wr_en     (wr_en),
    .idx       (cfg_idx),
    .wr_data   (wr_data),
    .cfg_rdata (cfg_rdata)
  );

  xlat_stage #(.ENTRIES(ENTRIES)) u_stage (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .xl_en     (xl_en),
    .in_valid  (in_valid),
    .in_addr   (in_addr),
    .lk_idx    (lk_idx),
    .lk_val    (lk_val),
    .out_valid (out_valid),
    .out_addr  (out_addr)
  );
endmodule

// File: rtl/addr_xlat_chk.sv
module addr_xlat_chk #(
  parameter int ENTRIES = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        xl_en,
  input logic        in_valid,
  input logic [31:0] in_addr,
  input logic        out_valid,
  input logic [31:0] out_addr,
  input logic        cfg_en,
  input logic        cfg_we,
  input logic [14:0] cfg_addr,
  input logic [31:0] cfg_rdata
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_addr));
  // R3
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_addr[19:0] == $past(in_addr[19:0]));
  // R4
  miss_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (32'(in_addr[31:20]) >= 32'(ENTRIES))) |=> out_addr == $past(in_addr));
  // R5
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !xl_en) |=> out_addr == $past(in_addr));
  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_en && !cfg_we) |=> $stable(cfg_rdata));
  // R8
  rdata_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[31:12] == 20'h0);
  // R9
  oob_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && !cfg_we && (32'(cfg_addr[14:3]) >= 32'(ENTRIES))) |=> cfg_rdata == 32'h0);
endmodule

bind addr_xlat addr_xlat_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .xl_en     (xl_en),
  .in_valid  (in_valid),
  .in_addr   (in_addr),
  .out_valid (out_valid),
  .out_addr  (out_addr),
  .cfg_en    (cfg_en),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_rdata (cfg_rdata)
);

// File: tb/addr_xlat_test.sv
`timescale 1ns/1ps
module addr_xlat_test;
  localparam int ENTRIES = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        xl_en, in_valid, out_valid;
  logic [31:0] in_addr, out_addr;
  logic        cfg_en, cfg_we;
  logic [14:0] cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;

  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;
  logic [11:0] model [ENTRIES];

  always #10 clk = ~clk;

  addr_xlat #(.ENTRIES(ENTRIES)) uut (
    .clk(clk), .rst_n(rst_n), .xl_en(xl_en), .in_valid(in_valid),
    .in_addr(in_addr), .out_valid(out_valid), .out_addr(out_addr),
    .cfg_en(cfg_en), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_xl(logic [31:0] a, logic en);
    if (en && a[31:20] < 12'(ENTRIES)) return {model[a[31:20]], a[19:0]};
    return a;
  endfunction

  // Drive one address; check it at the next negedge. Leaves in_valid high.
  task automatic xlate(string req, logic [31:0] a, logic en);
    logic [31:0] exp;
    exp = expect_xl(a, en);
    in_valid = 1'b1; in_addr = a; xl_en = en;
    @(negedge clk);
    check(req, {31'b0, out_valid}, 32'd1);
    check(req, out_addr, exp);
  endtask

  task automatic idle();
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic cfg_write(int idx, logic [2:0] lo, logic [31:0] d);
    cfg_en = 1'b1; cfg_we = 1'b1;
    cfg_addr = 15'((idx << 3) | int'(lo)); cfg_wdata = d;
    @(negedge clk);
    cfg_en = 1'b0; cfg_we = 1'b0;
    if (idx < ENTRIES) model[idx] = d[11:0];
  endtask

  task automatic cfg_read(string req, int idx, logic [31:0] exp);
    cfg_en = 1'b1; cfg_we = 1'b0; cfg_addr = 15'(idx << 3);
    @(negedge clk);
    cfg_en = 1'b0;
    check(req, cfg_rdata, exp);
  endtask

  task automatic t_reset();
    check("R1 out_valid", {31'b0, out_valid}, 32'd0);
    check("R1 out_addr", out_addr, 32'd0);
    check("R1 cfg_rdata", cfg_rdata, 32'd0);
  endtask

  task automatic t_identity();
    cfg_read("R6 entry0", 0, 32'd0);
    cfg_read("R6 entry5", 5, 32'd5);
    cfg_read("R6 entry63", 63, 32'd63);
    xlate("R6 identity xlate", 32'h0071_2345, 1'b1);
    check("R6 identity value", out_addr, 32'h0071_2345);
    idle();
  endtask

  task automatic t_program();
    cfg_write(3, 3'b101, 32'hFFFF_FABC);
    cfg_write(63, 3'b000, 32'h0000_0001);
    cfg_read("R7 ignored bits", 3, 32'h0000_0ABC);
    cfg_read("R8 readback 63", 63, 32'h0000_0001);
    xlate("R3 key3", 32'h0031_2345, 1'b1);
    check("R3 key3 literal", out_addr, 32'hABC1_2345);
    xlate("R3 key63", 32'h03FF_FFFF, 1'b1);
    xlate("R3 key5", 32'h0050_0000, 1'b1);
    idle();
  endtask

  task automatic t_hold();
    logic [31:0] prev;
    xlate("R2 load", 32'h0034_5678, 1'b1);
    prev = out_addr;
    in_valid = 1'b0; in_addr = 32'h0001_1111;
    @(negedge clk);
    check("R2 valid low", {31'b0, out_valid}, 32'd0);
    check("R2 addr held", out_addr, prev);
    @(negedge clk);
    check("R8 rdata held", cfg_rdata, 32'h0000_0001);
  endtask

  task automatic t_oob();
    xlate("R4 key 0x800", 32'h8001_2345, 1'b1);
    xlate("R4 key 64", 32'h0400_0001, 1'b1);
    idle();
    cfg_write(100, 3'b000, 32'h0000_0777);
    cfg_read("R9 oob read", 100, 32'd0);
    cfg_read("R9 alias untouched", 36, 32'd36);
  endtask

  task automatic t_bypass();
    xlate("R5 bypass key3", 32'h0030_0042, 1'b0);
    check("R5 bypass literal", out_addr, 32'h0030_0042);
    idle();
  endtask

  task automatic t_collide();
    cfg_en = 1'b1; cfg_we = 1'b1; cfg_addr = 15'(3 << 3); cfg_wdata = 32'h0000_0555;
    in_valid = 1'b1; in_addr = 32'h0030_0042; xl_en = 1'b1;
    @(negedge clk);
    cfg_en = 1'b0; cfg_we = 1'b0;
    check("R10 old value", out_addr, 32'hABC0_0042);
    model[3] = 12'h555;
    xlate("R10 new value", 32'h0030_0042, 1'b1);
    check("R10 new literal", out_addr, 32'h5550_0042);
    idle();
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_up();
    end
  end

  initial begin
    for (int k = 0; k < ENTRIES; k++) model[k] = 12'(k);
    rst_n = 1'b0; xl_en = 1'b1; in_valid = 1'b0; in_addr = '0;
    cfg_en = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_identity();
    t_program();
    t_hold();
    t_oob();
    t_bypass();
    t_collide();
    done = 1'b1;
    finish_up();
  end
endmodule